// File: doc/BRIEF.md
# Two-Stack 8-Bit Stack Processor

This block is a small Harvard-organised stack processor with an 8-bit datapath. It fetches one 10-bit instruction per cycle from a 256-word program store that sits outside the block, addressed by the program counter. Data lives in a separate 256-byte space. That space holds internal RAM and, in its upper address region, one 8-bit input port and one 8-bit output port. The working state is a top-of-stack register T, a 64-entry data stack holding the values below T, a 64-entry return stack, a carry flag and the program counter.

Eight instructions are decoded. Every result that lands in T passes through one ALU. A four-way multiplexer feeds the ALU's A input from the next-on-stack value, the byte at address T, the instruction's literal field, or the return-stack top. The second operand is always T. Because the ALU has a passthrough function, literal push, fetch, store and the transfers between the stacks all reuse the same path and need no separate address register. If an instruction would overflow or underflow either stack, the processor halts with a fault flag set and stays halted until reset.

Top module: `t8_stack_cpu`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the program counter is 0, T is 0, the output port is 0, the fault flag is 0, the carry is 0, both stacks are empty and all RAM bytes are 0.
- R2: Instruction bits [9:8] select the class. 00 pushes bits [7:0] as a literal: the old T goes onto the data stack. 01 jumps to address bits [7:0]. 11 is the operation group. Class 10 and any operation code not listed in R4 to R8 do nothing except advance the PC by one.
- R3: Every instruction except store completes in one cycle and advances the PC by one. The PC wraps from 255 to 0. Store takes two cycles.
- R4: The ALU operations pop where noted. 0x301 sets T to NOS AND T and pops. 0x302 sets T to NOT T. 0x303 sets T to NOS + T + carry, pops, and loads the carry-out into the carry flag. 0x304 sets T to T - 1.
- R5: 0x309 (skip-if-zero) tests T, pops one entry into T, and advances the PC by 2 if the tested value was zero, otherwise by 1.
- R6: 0x308 (fetch) replaces T with the byte at address T. Addresses whose top four bits are all ones return the input port.
- R7: 0x30A (store) writes NOS to address T and pops both values, so the entry below NOS becomes T. An address whose top four bits are all ones loads the output port instead of RAM. The PC holds for one extra cycle.
- R8: 0x30B moves T to the return stack and pops the data stack into T. 0x30C pushes T onto the data stack and loads T from the popped return-stack top.
- R9: An instruction that would push a 65th entry onto either stack sets the fault flag and changes no other state.
- R10: An instruction that pops an empty stack sets the fault flag and changes no other state. For store, this applies when fewer than two data-stack entries exist.
- R11: Once the fault flag is set, the PC, T, output port and fault flag hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Program store address (program counter) |
| imem_data | input | 10 | Instruction word at imem_addr, combinational |
| in_port | input | 8 | Input port, read by fetch from the I/O region |
| out_port | output | 8 | Output port register, written by store to the I/O region |
| tos | output | 8 | Current top-of-stack value T |
| stack_fault | output | 1 | Set on stack overflow or underflow; processor halted |

## Verification
The hardest states to reach are a completely full data stack and a completely full return stack. Filling the data stack takes 64 consecutive literal pushes. Filling the return stack needs 64 literal-then-transfer pairs, because every entry has to travel through T first. Directed programs build both depths exactly and then issue the one extra push. Further directed programs cover the skip-both-ways case, the wait state of store, I/O decoding and PC wrap. Random instruction streams then run against a behavioural queue-based model that is compared every cycle.

// File: rtl/t8_pkg.sv
`timescale 1ns/1ps
package t8_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int INSTR_W = 10;

    typedef enum logic [1:0] {
        CLS_LIT = 2'b00,
        CLS_JMP = 2'b01,
        CLS_RSV = 2'b10,
        CLS_OPS = 2'b11
    } cls_e;

    localparam logic [7:0] OPC_AND   = 8'h01;
    localparam logic [7:0] OPC_NOT   = 8'h02;
    localparam logic [7:0] OPC_ADC   = 8'h03;
    localparam logic [7:0] OPC_DEC   = 8'h04;
    localparam logic [7:0] OPC_FETCH = 8'h08;
    localparam logic [7:0] OPC_SKZ   = 8'h09;
    localparam logic [7:0] OPC_STORE = 8'h0A;
    localparam logic [7:0] OPC_TOR   = 8'h0B;
    localparam logic [7:0] OPC_FROMR = 8'h0C;

    typedef enum logic [1:0] {
        ASRC_NOS  = 2'd0,
        ASRC_MEM  = 2'd1,
        ASRC_LIT  = 2'd2,
        ASRC_RTOP = 2'd3
    } asrc_e;

    typedef enum logic [2:0] {
        FN_PASS = 3'd0,
        FN_AND  = 3'd1,
        FN_NOT  = 3'd2,
        FN_ADC  = 3'd3,
        FN_DEC  = 3'd4
    } alu_fn_e;

    typedef enum logic [1:0] {
        PC_NEXT  = 2'd0,
        PC_JUMP  = 2'd1,
        PC_SKZ   = 2'd2,
        PC_STALL = 2'd3
    } pcsel_e;

    typedef struct packed {
        asrc_e   asrc;
        alu_fn_e fn;
        logic    t_we;
        logic    c_we;
        logic    dpush;
        logic    dpop;
        logic    need2;
        logic    rpush;
        logic    rpop;
        logic    mem_we;
        pcsel_e  pcsel;
    } ctrl_t;

    // Control word for one instruction; store_tail marks the second store cycle.
    function automatic ctrl_t decode(input logic [INSTR_W-1:0] ins, input logic store_tail);
        ctrl_t c;
        c = '{asrc: ASRC_NOS, fn: FN_PASS, pcsel: PC_NEXT, default: 1'b0};
        unique case (cls_e'(ins[9:8]))
            CLS_LIT: begin
                c.asrc  = ASRC_LIT;
                c.t_we  = 1'b1;
                c.dpush = 1'b1;
            end
            CLS_JMP: c.pcsel = PC_JUMP;
            CLS_RSV: ;
            CLS_OPS: begin
                case (ins[7:0])
                    OPC_AND:   begin c.fn = FN_AND; c.t_we = 1'b1; c.dpop = 1'b1; end
                    OPC_NOT:   begin c.fn = FN_NOT; c.t_we = 1'b1; end
                    OPC_ADC:   begin c.fn = FN_ADC; c.t_we = 1'b1; c.c_we = 1'b1; c.dpop = 1'b1; end
                    OPC_DEC:   begin c.fn = FN_DEC; c.t_we = 1'b1; end
                    OPC_FETCH: begin c.asrc = ASRC_MEM; c.t_we = 1'b1; end
                    OPC_SKZ:   begin c.t_we = 1'b1; c.dpop = 1'b1; c.pcsel = PC_SKZ; end
                    OPC_STORE: begin
                        c.t_we = 1'b1;
                        c.dpop = 1'b1;
                        if (!store_tail) begin
                            c.mem_we = 1'b1;
                            c.need2  = 1'b1;
                            c.pcsel  = PC_STALL;
                        end
                    end
                    OPC_TOR:   begin c.t_we = 1'b1; c.dpop = 1'b1; c.rpush = 1'b1; end
                    OPC_FROMR: begin
                        c.asrc  = ASRC_RTOP;
                        c.t_we  = 1'b1;
                        c.dpush = 1'b1;
                        c.rpop  = 1'b1;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/t8_lifo.sv
`timescale 1ns/1ps
module t8_lifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               top,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_m1;

    assign cnt_m1 = cnt_q - 1'b1;
    assign top    = mem[cnt_m1[PW-1:0]];
    assign count  = cnt_q;

    always_ff @(posedge clk) begin
        if (push) mem[cnt_q[PW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (push) cnt_q <= cnt_q + 1'b1;
        else if (pop)  cnt_q <= cnt_m1;
    end
endmodule

// File: rtl/t8_alu.sv
`timescale 1ns/1ps
module t8_alu
    import t8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         cout
);
    logic [W:0] sum;
    assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

    always_comb begin
        cout = 1'b0;
        unique case (fn)
            FN_AND:  y = a & b;
            FN_NOT:  y = ~b;
            FN_ADC:  begin y = sum[W-1:0]; cout = sum[W]; end
            FN_DEC:  y = b - 1'b1;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/t8_dmem.sv
`timescale 1ns/1ps
module t8_dmem #(
    parameter int DW      = 8,
    parameter int AW      = 8,
    parameter int IO_BITS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] in_port,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] out_port
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] ram [WORDS];
    logic          io_sel;

    assign io_sel = &addr[AW-1 -: IO_BITS];
    assign rdata  = io_sel ? in_port : ram[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) ram[i] <= '0;
        end else if (we && !io_sel) begin
            ram[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                out_port <= '0;
        else if (we && io_sel)  out_port <= wdata;
    end
endmodule

// File: rtl/t8_stack_cpu.sv
`timescale 1ns/1ps
module t8_stack_cpu
    import t8_pkg::*;
#(
    parameter int DW       = t8_pkg::DATA_W,
    parameter int AW       = t8_pkg::ADDR_W,
    parameter int IW       = t8_pkg::INSTR_W,
    parameter int DS_DEPTH = 64,
    parameter int RS_DEPTH = 64,
    parameter int IO_BITS  = 4
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] imem_addr,
    input  logic [IW-1:0] imem_data,
    input  logic [DW-1:0] in_port,
    output logic [DW-1:0] out_port,
    output logic [DW-1:0] tos,
    output logic          stack_fault
);
    localparam int DCW = $clog2(DS_DEPTH+1);
    localparam int RCW = $clog2(RS_DEPTH+1);
    localparam logic [DCW-1:0] D_FULL = DCW'(DS_DEPTH);
    localparam logic [RCW-1:0] R_FULL = RCW'(RS_DEPTH);

    logic [AW-1:0]  pc_q, pc_nxt;
    logic [DW-1:0]  t_q;
    logic           c_q;
    logic           st_tail_q;
    logic           halt_q;

    ctrl_t          ctl;
    logic [DW-1:0]  nos, rtop, mem_rd, a_mux, alu_y;
    logic           alu_c;
    logic [DCW-1:0] d_cnt;
    logic [RCW-1:0] r_cnt;
    logic           underflow, overflow, go;

    assign ctl = decode(imem_data, st_tail_q);

    assign underflow = (ctl.dpop  && d_cnt == '0)
                    || (ctl.need2 && d_cnt < DCW'(2))
                    || (ctl.rpop  && r_cnt == '0);
    assign overflow  = (ctl.dpush && d_cnt == D_FULL)
                    || (ctl.rpush && r_cnt == R_FULL);
    assign go        = !halt_q && !underflow && !overflow;

    t8_lifo #(.W(DW), .DEPTH(DS_DEPTH)) u_dstack (
        .clk   (clk),
        .rst   (rst),
        .push  (go && ctl.dpush),
        .pop   (go && ctl.dpop),
        .din   (t_q),
        .top   (nos),
        .count (d_cnt)
    );

    t8_lifo #(.W(DW), .DEPTH(RS_DEPTH)) u_rstack (
        .clk   (clk),
        .rst   (rst),
        .push  (go && ctl.rpush),
        .pop   (go && ctl.rpop),
        .din   (t_q),
        .top   (rtop),
        .count (r_cnt)
    );

    t8_dmem #(.DW(DW), .AW(AW), .IO_BITS(IO_BITS)) u_dmem (
        .clk      (clk),
        .rst      (rst),
        .we       (go && ctl.mem_we),
        .addr     (t_q[AW-1:0]),
        .wdata    (nos),
        .in_port  (in_port),
        .rdata    (mem_rd),
        .out_port (out_port)
    );

    always_comb begin
        unique case (ctl.asrc)
            ASRC_MEM:  a_mux = mem_rd;
            ASRC_LIT:  a_mux = DW'(imem_data[7:0]);
            ASRC_RTOP: a_mux = rtop;
            default:   a_mux = nos;
        endcase
    end

    t8_alu #(.W(DW)) u_alu (
        .a    (a_mux),
        .b    (t_q),
        .cin  (c_q),
        .fn   (ctl.fn),
        .y    (alu_y),
        .cout (alu_c)
    );

    always_comb begin
        unique case (ctl.pcsel)
            PC_JUMP:  pc_nxt = AW'(imem_data[7:0]);
            PC_SKZ:   pc_nxt = (t_q == '0) ? pc_q + AW'(2) : pc_q + AW'(1);
            PC_STALL: pc_nxt = pc_q;
            default:  pc_nxt = pc_q + AW'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            t_q       <= '0;
            c_q       <= 1'b0;
            st_tail_q <= 1'b0;
            halt_q    <= 1'b0;
        end else if (!halt_q) begin
            if (!go) begin
                halt_q <= 1'b1;
            end else begin
                pc_q      <= pc_nxt;
                st_tail_q <= (ctl.pcsel == PC_STALL);
                if (ctl.t_we) t_q <= alu_y;
                if (ctl.c_we) c_q <= alu_c;
            end
        end
    end

    assign imem_addr   = pc_q;
    assign tos         = t_q;
    assign stack_fault = halt_q;
endmodule

// File: rtl/t8_cpu_checker.sv
`timescale 1ns/1ps
module t8_cpu_checker #(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int IW       = 10,
    parameter int DCW      = 7,
    parameter int RCW      = 7,
    parameter int DS_DEPTH = 64,
    parameter int RS_DEPTH = 64
) (
    input logic           clk,
    input logic           rst,
    input logic [AW-1:0]  pc,
    input logic [IW-1:0]  ins,
    input logic [DW-1:0]  tos,
    input logic [DW-1:0]  outp,
    input logic           fault,
    input logic [DCW-1:0] d_cnt,
    input logic [RCW-1:0] r_cnt,
    input logic           st_tail
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && tos == '0 && outp == '0 && !fault && d_cnt == '0 && r_cnt == '0));

    assert_jump_target_R2: assert property (@(posedge clk) disable iff (rst)
        (!fault && ins[9:8] == 2'b01) |=> (pc == AW'($past(ins[7:0]))));

    assert_lit_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!fault && ins[9:8] == 2'b00 && d_cnt < DCW'(DS_DEPTH))
        |=> (pc == $past(pc) + AW'(1) && tos == DW'($past(ins[7:0]))));

    assert_skz_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (!fault && ins == 10'h309 && tos == '0 && d_cnt != '0) |=> (pc == $past(pc) + AW'(2)));

    assert_store_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (!fault && ins == 10'h30A && !st_tail && d_cnt >= DCW'(2)) |=> (pc == $past(pc) && st_tail));

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (d_cnt <= DCW'(DS_DEPTH) && r_cnt <= RCW'(RS_DEPTH)));

    assert_halt_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        fault |=> (fault && $stable(pc) && $stable(tos) && $stable(outp)));
endmodule

bind t8_stack_cpu t8_cpu_checker #(
    .AW(AW), .DW(DW), .IW(IW), .DCW(DCW), .RCW(RCW),
    .DS_DEPTH(DS_DEPTH), .RS_DEPTH(RS_DEPTH)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (imem_addr),
    .ins     (imem_data),
    .tos     (tos),
    .outp    (out_port),
    .fault   (stack_fault),
    .d_cnt   (d_cnt),
    .r_cnt   (r_cnt),
    .st_tail (st_tail_q)
);

// File: tb/test_t8_stack_cpu.sv
`timescale 1ns/1ps
module test_t8_stack_cpu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] imem_addr;
    logic [9:0] imem_data;
    logic [7:0] in_port = 8'h00;
    logic [7:0] out_port;
    logic [7:0] tos;
    logic       stack_fault;

    logic [9:0] rom [256];
    assign imem_data = rom[imem_addr];

    always #4 clk = ~clk;

    t8_stack_cpu i_t8_stack_cpu (
        .clk         (clk),
        .rst         (rst),
        .imem_addr   (imem_addr),
        .imem_data   (imem_data),
        .in_port     (in_port),
        .out_port    (out_port),
        .tos         (tos),
        .stack_fault (stack_fault)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Behavioural reference state
    logic [7:0] m_pc, m_t, m_out;
    logic       m_c, m_fault, m_st;
    logic [7:0] m_ram [256];
    logic [7:0] dq [$];
    logic [7:0] rq [$];

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 8'h00; m_t = 8'h00; m_out = 8'h00;
        m_c = 1'b0; m_fault = 1'b0; m_st = 1'b0;
        for (int i = 0; i < 256; i++) m_ram[i] = 8'h00;
        dq.delete();
        rq.delete();
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] a);
        return (a[7:4] == 4'hF) ? in_port : m_ram[a];
    endfunction

    task automatic model_step();
        logic [9:0] ins;
        logic [7:0] op, npc, nos;
        logic [8:0] s;
        if (m_fault) return;
        ins = rom[m_pc];
        op  = ins[7:0];
        npc = m_pc + 8'd1;
        case (ins[9:8])
            2'b00: if (dq.size() == 64) m_fault = 1'b1;
                   else begin dq.push_back(m_t); m_t = op; end
            2'b01: npc = op;
            2'b10: ;
            default: case (op)
                8'h01: if (dq.size() == 0) m_fault = 1'b1;
                       else begin nos = dq.pop_back(); m_t = nos & m_t; end
                8'h02: m_t = ~m_t;
                8'h03: if (dq.size() == 0) m_fault = 1'b1;
                       else begin
                           nos = dq.pop_back();
                           s = {1'b0, nos} + {1'b0, m_t} + {8'd0, m_c};
                           m_t = s[7:0]; m_c = s[8];
                       end
                8'h04: m_t = m_t - 8'd1;
                8'h08: m_t = m_read(m_t);
                8'h09: if (dq.size() == 0) m_fault = 1'b1;
                       else begin
                           if (m_t == 8'h00) npc = m_pc + 8'd2;
                           m_t = dq.pop_back();
                       end
                8'h0A: if (!m_st) begin
                           if (dq.size() < 2) m_fault = 1'b1;
                           else begin
                               nos = dq.pop_back();
                               if (m_t[7:4] == 4'hF) m_out = nos; else m_ram[m_t] = nos;
                               m_t = nos; m_st = 1'b1; npc = m_pc;
                           end
                       end else begin
                           m_t = dq.pop_back(); m_st = 1'b0;
                       end
                8'h0B: if (dq.size() == 0 || rq.size() == 64) m_fault = 1'b1;
                       else begin rq.push_back(m_t); m_t = dq.pop_back(); end
                8'h0C: if (rq.size() == 0 || dq.size() == 64) m_fault = 1'b1;
                       else begin dq.push_back(m_t); m_t = rq.pop_back(); end
                default: ;
            endcase
        endcase
        if (!m_fault) m_pc = npc;
    endtask

    task automatic compare_all();
        check("R3", "pc", int'(imem_addr), int'(m_pc));
        check("R4", "tos", int'(tos), int'(m_t));
        check("R7", "out_port", int'(out_port), int'(m_out));
        check("R9", "stack_fault", int'(stack_fault), int'(m_fault));
    endtask

    // Compare at the current falling edge, then advance n clock cycles.
    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            compare_all();
            model_step();
            @(negedge clk);
        end
        compare_all();
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = 10'h200;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        model_reset();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [9:0] rand_ins();
        int w;
        logic [7:0] ops [10] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h05};
        w = $urandom_range(0, 99);
        if (w < 38)      return {2'b00, 8'($urandom)};
        else if (w < 42) return {2'b01, 8'($urandom)};
        else if (w < 44) return {2'b10, 8'($urandom)};
        else             return {2'b11, ops[$urandom_range(0, 9)]};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // ---- Program A: ALU, carry, store to RAM and port, fetch ----
        clear_rom();
        rom[0]  = 10'h00C; rom[1]  = 10'h00A; rom[2]  = 10'h301; rom[3]  = 10'h302;
        rom[4]  = 10'h304; rom[5]  = 10'h0F0; rom[6]  = 10'h30A; rom[7]  = 10'h0C8;
        rom[8]  = 10'h064; rom[9]  = 10'h303; rom[10] = 10'h001; rom[11] = 10'h303;
        rom[12] = 10'h020; rom[13] = 10'h30A; rom[14] = 10'h020; rom[15] = 10'h308;
        rom[16] = 10'h0F0; rom[17] = 10'h30A; rom[18] = 10'h112;
        do_reset();
        check("R1", "reset pc", int'(imem_addr), 0);
        check("R1", "reset tos", int'(tos), 0);
        check("R1", "reset out_port", int'(out_port), 0);
        check("R1", "reset fault", int'(stack_fault), 0);
        run(5);
        check("R4", "and/not/dec result", int'(tos), 8'hF6);
        run(3);
        check("R7", "store to port", int'(out_port), 8'hF6);
        check("R7", "store pops both", int'(tos), 0);
        run(30);
        check("R4", "adc with carry via RAM", int'(out_port), 8'h2E);
        check("R2", "jump self loop", int'(imem_addr), 18);

        // ---- Program B: fetch input, skip both ways, stack transfers, underflow ----
        clear_rom();
        in_port = 8'h5A;
        rom[0] = 10'h0F3; rom[1] = 10'h308; rom[2] = 10'h30B; rom[3] = 10'h000;
        rom[4] = 10'h309; rom[5] = 10'h077; rom[6] = 10'h001; rom[7] = 10'h309;
        rom[8] = 10'h30C; rom[9] = 10'h0F1; rom[10] = 10'h30A; rom[11] = 10'h30C;
        do_reset();
        run(5);
        check("R5", "skip taken on zero", int'(imem_addr), 6);
        run(2);
        check("R5", "no skip on nonzero", int'(imem_addr), 8);
        check("R5", "skz pops", int'(tos), 0);
        run(1);
        check("R8", "return stack round trip", int'(tos), 8'h5A);
        check("R6", "fetch from input port", int'(tos), 8'h5A);
        run(3);
        check("R7", "store wait then port", int'(out_port), 8'h5A);
        run(1);
        check("R10", "return underflow fault", int'(stack_fault), 1);
        check("R10", "pc held on fault", int'(imem_addr), 11);
        run(6);
        check("R11", "still halted", int'(stack_fault), 1);
        check("R11", "pc frozen", int'(imem_addr), 11);
        check("R11", "port frozen", int'(out_port), 8'h5A);

        // ---- Program C: data stack overflow ----
        clear_rom();
        for (int i = 0; i < 65; i++) rom[i] = {2'b00, 8'(i + 1)};
        rom[65] = 10'h141;
        do_reset();
        run(64);
        check("R9", "64 entries no fault", int'(stack_fault), 0);
        check("R9", "top after 64 pushes", int'(tos), 64);
        run(1);
        check("R9", "65th push faults", int'(stack_fault), 1);
        check("R9", "tos unchanged", int'(tos), 64);
        check("R9", "pc unchanged", int'(imem_addr), 64);

        // ---- Program D: return stack overflow ----
        clear_rom();
        for (int i = 0; i < 65; i++) begin
            rom[2*i]     = {2'b00, 8'(i + 1)};
            rom[2*i + 1] = 10'h30B;
        end
        do_reset();
        run(128);
        check("R9", "return stack full no fault", int'(stack_fault), 0);
        run(2);
        check("R9", "return overflow faults", int'(stack_fault), 1);
        check("R9", "pc at transfer", int'(imem_addr), 129);

        // ---- Program E: no-ops, PC wrap, empty-stack pop ----
        clear_rom();
        rom[0] = 10'h2AB; rom[1] = 10'h305; rom[2] = 10'h3FF; rom[3] = 10'h1FE;
        rom[254] = 10'h009; rom[255] = 10'h008;
        do_reset();
        run(3);
        check("R2", "no-ops advance pc", int'(imem_addr), 3);
        check("R2", "no-ops keep tos", int'(tos), 0);
        run(1);
        check("R2", "jump to FE", int'(imem_addr), 8'hFE);
        run(2);
        check("R3", "pc wraps to 0", int'(imem_addr), 0);
        check("R3", "literal after wrap", int'(tos), 8);
        clear_rom();
        rom[0] = 10'h301;
        do_reset();
        run(1);
        check("R10", "and on empty stack", int'(stack_fault), 1);
        check("R10", "tos unchanged", int'(tos), 0);

        // ---- Random streams against the model ----
        for (int p = 0; p < 40; p++) begin
            for (int i = 0; i < 256; i++) rom[i] = rand_ins();
            in_port = 8'($urandom);
            do_reset();
            run(400);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule